// File: doc/BRIEF.md
# Bit-Masked Single-Port Synchronous RAM

This block is a synthesizable behavioural model of a single-port synchronous RAM of 256 words by 8 bits. It has separate write-data and read-data buses and a per-bit write mask. Every input (chip select, write strobe, mask, address and data) is sampled on the rising clock edge, and that edge starts every operation. The select, the write strobe and the mask are all active-low. The read port `q` is registered. It changes only on a read cycle and keeps its last read value through write cycles and idle cycles, so write data never passes straight through to `q`.

An arming sequencer enforces a start-up rule: the chip select must be seen inactive (high) on at least one clock edge before any access is honoured. The sequencer has two states. `ST_UNARMED` is entered on reset and moves to `ST_ARMED` (transition "arm") on the first edge that samples `cen_n` high. `ST_ARMED` then holds until the next reset (transition "hold"). In `ST_UNARMED`, an edge that samples `cen_n` low stays in `ST_UNARMED` (transition "stall"). That blocked access leaves the array untouched and drives `q` to unknown. The `ready` output shows the sequencer state. Reset does not clear the array or `q`, and both power up undefined, so a word must be written before it is read.

Top module: `sram_bm_256x8`

## Requirements
- R1: The array holds 256 words of 8 bits, and the 8-bit `addr` selects each of them independently.
- R2: When armed, an edge with `cen_n`=0 and `gwen_n`=1 loads `q` with the word at `addr`. `q` shows it from that edge onward.
- R3: An edge with `cen_n`=1 changes no word of the array and leaves `q` unchanged, whatever the other inputs are.
- R4: When armed, an edge with `cen_n`=0, `gwen_n`=0 and `wmask_n`=8'h00 replaces the addressed word with `d`.
- R5: `q` keeps its value across every write edge.
- R6: On a write edge, bit i of the addressed word takes `d[i]` when `wmask_n[i]`=0 and keeps its old value when `wmask_n[i]`=1. With `wmask_n`=8'hFF, the write changes nothing.
- R7: While `rst_n`=0, `ready` is 0. The first edge that samples `cen_n`=1 sets `ready` to 1, and `ready` then stays 1 until reset.
- R8: While `ready`=0, an edge with `cen_n`=0 changes no word of the array, and `ready` stays 0.
- R9: A read in the cycle right after a write to the same address returns the newly merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the arming sequencer |
| cen_n | input | 1 | Active-low chip select |
| gwen_n | input | 1 | Active-low write strobe (0 = write, 1 = read) |
| wmask_n | input | 8 | Active-low per-bit write mask |
| addr | input | 8 | Word address |
| d | input | 8 | Write data |
| q | output | 8 | Registered read data |
| ready | output | 1 | Sequencer armed |

## Verification
On a masked write, the array reads the old word and merges it with `d` in the same cycle. A read that follows in the very next cycle must see the merged result. The bench sweeps every address with a full write, then does a masked write whose mask depends on the address, followed at once by a read of that address. The read-back is judged against `(old & mask) | (d & ~mask)`, computed from a reference array. A second overlap is arming and holding in one edge: the bench releases reset with the select low, tries a write that must be discarded, then gives one idle edge that both arms the block and must leave `q` and the array alone. A later read shows that the pre-reset word survived.

// File: rtl/sram_pkg.sv
package sram_pkg;
    typedef enum logic [0:0] {
        ST_UNARMED = 1'b0,
        ST_ARMED   = 1'b1
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_READ    = 2'd1,
        OP_WRITE   = 2'd2,
        OP_BLOCKED = 2'd3
    } op_t;
endpackage

// File: rtl/sram_seq.sv
module sram_seq
    import sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cen_n,
    input  logic gwen_n,
    output op_t  op,
    output logic ready
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        op      = OP_IDLE;
        unique case (state_q)
            ST_UNARMED: begin
                if (cen_n) state_d = ST_ARMED;   // arm
                else       op      = OP_BLOCKED; // stall
            end
            ST_ARMED: begin
                if (!cen_n) op = gwen_n ? OP_READ : OP_WRITE;
            end
            default: state_d = ST_UNARMED;
        endcase
    end

    assign ready = (state_q == ST_ARMED);

    assert_arm_on_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ready);
    assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    assert_stall_keeps_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !cen_n) |=> !ready);
endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d,
    input  logic [DATA_W-1:0] wmask_n,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] merged;

    assign rd_data = mem[addr];

    for (genvar b = 0; b < DATA_W; b++) begin : g_merge
        assign merged[b] = wmask_n[b] ? rd_data[b] : d[b];
    end

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= merged;
    end

    assert_written_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (((mem[$past(addr)] ^ $past(d)) & ~$past(wmask_n)) == '0));
    assert_masked_bits_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (((mem[$past(addr)] ^ $past(rd_data)) & $past(wmask_n)) == '0));
    assert_no_write_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (mem[$past(addr)] === $past(rd_data)));
endmodule

// File: rtl/sram_qport.sv
module sram_qport
    import sram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  op_t               op,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        unique case (op)
            OP_READ:    q <= rd_data;
            OP_BLOCKED: q <= 'x;
            default:    q <= q;
        endcase
    end
endmodule

// File: rtl/sram_bm_256x8.sv
module sram_bm_256x8
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              gwen_n,
    input  logic [DATA_W-1:0] wmask_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q,
    output logic              ready
);
    op_t               op;
    logic [DATA_W-1:0] rd_data;

    sram_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cen_n  (cen_n),
        .gwen_n (gwen_n),
        .op     (op),
        .ready  (ready)
    );

    sram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (op == OP_WRITE),
        .addr    (addr),
        .d       (d),
        .wmask_n (wmask_n),
        .rd_data (rd_data)
    );

    sram_qport #(.DATA_W(DATA_W)) u_qport (
        .clk     (clk),
        .op      (op),
        .rd_data (rd_data),
        .q       (q)
    );

    assert_read_loads_q_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !cen_n && gwen_n) |=> (q == $past(rd_data)));
    assert_q_hold_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !cen_n && !gwen_n) |=> $stable(q));
    assert_q_hold_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(q));
endmodule

// File: tb/sim_sram_bm_256x8.sv
module sim_sram_bm_256x8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cen_n = 1'b0;
    logic       gwen_n = 1'b1;
    logic [7:0] wmask_n = 8'hFF;
    logic [7:0] addr = 8'h00;
    logic [7:0] d = 8'h00;
    logic [7:0] q;
    logic       ready;

    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 1'b0;
    bit   armed = 1'b0;
    logic [7:0] ref_mem [256];
    logic [7:0] exp_q = 8'h00;

    always #4 clk = ~clk;

    sram_bm_256x8 u0 (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .gwen_n(gwen_n),
        .wmask_n(wmask_n), .addr(addr), .d(d), .q(q), .ready(ready)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock cycle: drive after a falling edge, return at the next falling edge.
    task automatic cyc(input logic c, input logic g, input logic [7:0] m,
                       input logic [7:0] a, input logic [7:0] dd);
        cen_n = c; gwen_n = g; wmask_n = m; addr = a; d = dd;
        @(posedge clk);
        if (rst_n) begin
            if (!armed) begin
                if (c) armed = 1'b1;
            end else if (!c) begin
                if (g) exp_q = ref_mem[a];
                else   ref_mem[a] = (ref_mem[a] & m) | (dd & ~m);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 ready low in reset", {7'd0, ready}, 8'h00);
        rst_n = 1'b1;
        // first edge after release has cen_n high: arms
        cyc(1'b1, 1'b1, 8'hFF, 8'h00, 8'h00);
        chk("R7 ready after idle edge", {7'd0, ready}, 8'h01);

        // R1 R4 R5: full write of every word; q must not move on writes
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'h0B);
        cyc(1'b0, 1'b1, 8'hFF, 8'h00, 8'h00);
        for (int a = 1; a < 256; a++) begin
            cyc(1'b0, 1'b0, 8'h00, 8'(a), 8'(a * 37 + 11));
            chk("R5 q held on write", q, exp_q);
        end
        for (int a = 0; a < 256; a++) begin
            cyc(1'b0, 1'b1, 8'hFF, 8'(a), 8'h00);
            chk("R1 R2 R4 read after full write", q, 8'(a * 37 + 11));
        end

        // R6 R9: masked write, then read back in the next cycle
        for (int a = 0; a < 256; a++) begin
            logic [7:0] m;
            logic [7:0] dd;
            logic [7:0] old;
            m = 8'(a) ^ 8'h5A;
            dd = ~8'(a * 37 + 11);
            old = 8'(a * 37 + 11);
            cyc(1'b0, 1'b0, m, 8'(a), dd);
            cyc(1'b0, 1'b1, 8'hFF, 8'(a), 8'h00);
            chk("R6 R9 masked merge read-back", q, (old & m) | (dd & ~m));
        end

        // R6: all-high mask changes nothing
        cyc(1'b0, 1'b0, 8'hFF, 8'd3, 8'hC3);
        cyc(1'b0, 1'b1, 8'hFF, 8'd3, 8'h00);
        chk("R6 all-high mask no change", q, ref_mem[3]);

        // R3: standby with write-looking inputs; q held, array untouched
        cyc(1'b0, 1'b1, 8'hFF, 8'd7, 8'h00);
        for (int k = 0; k < 8; k++) begin
            cyc(1'b1, 1'b0, 8'h00, 8'(k + 7), 8'hE1);
            chk("R3 q held in standby", q, exp_q);
        end
        for (int k = 0; k < 8; k++) begin
            cyc(1'b0, 1'b1, 8'hFF, 8'(k + 7), 8'h00);
            chk("R3 array untouched by standby", q, ref_mem[k + 7]);
        end

        // Mixed pseudo-random traffic against the reference array
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            logic c;
            logic g;
            r = $urandom;
            c = (r % 5) == 0;
            g = r[3];
            cyc(c, g, 8'(r >> 8), 8'(r >> 16), 8'(r >> 24));
            chk(c ? "R3 random standby" : (g ? "R2 random read" : "R5 random write"), q, exp_q);
        end

        // R8: a blocked access before arming leaves the array alone
        cyc(1'b0, 1'b0, 8'h00, 8'd5, 8'hA5);
        cyc(1'b0, 1'b1, 8'hFF, 8'd5, 8'h00);
        chk("R8 setup write", q, 8'hA5);
        @(negedge clk); rst_n = 1'b0; armed = 1'b0;
        cen_n = 1'b0;
        @(negedge clk);
        chk("R7 ready cleared by reset", {7'd0, ready}, 8'h00);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 8'h00, 8'd5, 8'h3C);
        chk("R8 ready stays low on blocked access", {7'd0, ready}, 8'h00);
        cyc(1'b1, 1'b0, 8'h00, 8'd5, 8'h3C);
        chk("R7 arm after blocked access", {7'd0, ready}, 8'h01);
        cyc(1'b0, 1'b1, 8'hFF, 8'd5, 8'h00);
        chk("R8 word survives blocked write", q, 8'hA5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule